// File: doc/BRIEF.md
# Macro ALU with Persistent Carry

This block is the execute stage arithmetic of a small 32-bit macro processor. On each cycle where an instruction is issued it takes two register operands, a two-bit unit select, a five-bit operation code and the raw 32-bit instruction word. It updates a registered result and a single carry flag that lives from one instruction to the next.

The unit select picks one of three paths:

- **Register-register path.** It covers add and subtract, with and without carry or borrow, plus five bitwise operations.
- **Add-immediate path.** It adds a signed 18-bit constant taken from the upper bits of the instruction word.
- **Field-merge path.** It lifts a bit field out of operand B and places it into operand A. The source position, field width and destination position come from three 5-bit slices of the instruction word.

A code that no path implements produces a zero result. It raises a one-cycle illegal pulse and leaves the carry alone.

Fetch, branching, register storage and the routing of the result are handled elsewhere.

Top module: `macro_alu`

## Requirements
- R1: While `rst_n` is low, and after its release until the first issue, `result_o` is 0, `carry_o` is 0 and `illegal_o` is 0.
- R2: Results and the carry change only at a rising clock edge where `issue_i` is high, and are visible right after that edge. With `issue_i` low, `result_o` and `carry_o` hold and `illegal_o` is 0.
- R3: With `unit_i`=0, code 0 gives a+b and code 1 gives a+b+carry. Both set the carry to the unsigned carry-out of bit 31.
- R4: With `unit_i`=0, code 2 gives a-b and code 3 gives a-b-(1-carry). Both set the carry to 1 exactly when no borrow occurs, meaning the unsigned a is at least the amount subtracted.
- R5: With `unit_i`=0, the codes are: 8 gives a^b, 9 gives a|b, 10 gives a&b, 11 gives a&~b, and 12 gives ~(a&b). None of them changes the carry.
- R6: With `unit_i`=1, the result is a plus the sign-extended value of `insn_i[31:14]`, and the carry is unchanged.
- R7: With `unit_i`=2, the source position is `insn_i[21:17]`, the size is `insn_i[26:22]` and the destination position is `insn_i[31:27]`. With mask=(1<<size)-1, the result is (a & ~(mask<<dst)) | (((b>>src)&mask)<<dst), truncated to 32 bits. The carry is unchanged.
- R8: A field merge with size 0 returns operand A unchanged.
- R9: With `unit_i`=0, codes 4 to 7 and 13 to 31 are illegal, and `unit_i`=3 is illegal. An illegal issue sets the result to 0 and leaves the carry unchanged. It also drives `illegal_o` high for exactly the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Execute the presented instruction at this edge |
| unit_i | input | 2 | Path select: 0 register ALU, 1 add-immediate, 2 field merge, 3 reserved |
| alu_op_i | input | 5 | Operation code for the register ALU path |
| insn_i | input | 32 | Instruction word carrying immediate and field slices |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| result_o | output | 32 | Registered result |
| carry_o | output | 1 | Persistent carry flag |
| illegal_o | output | 1 | One-cycle pulse after an illegal issue |

## Verification
The carry is the only state that outlives an instruction. A wrong carry is invisible at first: it surfaces only at the next add-with-carry or subtract-with-borrow, where the sum or difference is off by one. It can also show as a carry that should have held across a logic, immediate or illegal instruction. The bench therefore interleaves carry-producing, carry-preserving and carry-consuming instructions, and compares result, carry and illegal pulse against a behavioural model on every cycle. A mistake in the field mask or in a shift shows in the very next result. The cases with size 0 and with a destination near bit 31 expose truncation faults.

// File: rtl/macro_alu_pkg.sv
package macro_alu_pkg;

  typedef enum logic [1:0] {
    UNIT_ALU   = 2'd0,
    UNIT_ADDI  = 2'd1,
    UNIT_FIELD = 2'd2,
    UNIT_RSVD  = 2'd3
  } unit_e;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBB  = 5'd3,
    OP_XOR  = 5'd8,
    OP_OR   = 5'd9,
    OP_AND  = 5'd10,
    OP_ANDN = 5'd11,
    OP_NAND = 5'd12
  } alu_op_e;

endpackage

// File: rtl/macro_alu_arith.sv
module macro_alu_arith
  import macro_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [4:0]    op_i,
  input  logic          carry_i,
  output logic [DW-1:0] res_o,
  output logic          carry_o,
  output logic          carry_wr_o,
  output logic          bad_o
);

  logic [DW-1:0] addend;
  logic          cin;
  logic [DW:0]   sum;

  // One adder serves all four arithmetic codes: subtraction adds ~b.
  always_comb begin
    addend = b_i;
    cin    = 1'b0;
    unique case (op_i)
      OP_ADC:  cin = carry_i;
      OP_SUB:  begin addend = ~b_i; cin = 1'b1;    end
      OP_SBB:  begin addend = ~b_i; cin = carry_i; end
      default: ;
    endcase
    sum = {1'b0, a_i} + {1'b0, addend} + {{DW{1'b0}}, cin};
  end

  always_comb begin
    res_o      = '0;
    carry_o    = carry_i;
    carry_wr_o = 1'b0;
    bad_o      = 1'b0;
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        res_o      = sum[DW-1:0];
        carry_o    = sum[DW];
        carry_wr_o = 1'b1;
      end
      OP_XOR:  res_o = a_i ^ b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_ANDN: res_o = a_i & ~b_i;
      OP_NAND: res_o = ~(a_i & b_i);
      default: bad_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/macro_alu_field.sv
module macro_alu_field #(
  parameter int DW = 32,
  parameter int FW = 5
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [FW-1:0] src_i,
  input  logic [FW-1:0] size_i,
  input  logic [FW-1:0] dst_i,
  output logic [DW-1:0] res_o
);

  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] mask;
  logic [DW-1:0] slice;
  logic [DW-1:0] hole;

  always_comb begin
    mask  = (ONE << size_i) - ONE;
    slice = (b_i >> src_i) & mask;
    hole  = mask << dst_i;
    res_o = (a_i & ~hole) | (slice << dst_i);
  end

endmodule

// File: rtl/macro_alu.sv
module macro_alu
  import macro_alu_pkg::*;
#(
  parameter int DW      = 32,
  parameter int FW      = 5,
  parameter int IMM_LSB = 14,
  parameter int SRC_LSB = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic [1:0]    unit_i,
  input  logic [4:0]    alu_op_i,
  input  logic [DW-1:0] insn_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  output logic [DW-1:0] result_o,
  output logic          carry_o,
  output logic          illegal_o
);

  localparam int SIZE_LSB = SRC_LSB + FW;
  localparam int DST_LSB  = SIZE_LSB + FW;
  localparam int IMM_W    = DW - IMM_LSB;

  // Instruction word slices
  logic [IMM_W-1:0] imm_raw;
  logic [DW-1:0]    imm_ext;
  logic [FW-1:0]    f_src, f_size, f_dst;

  assign imm_raw = insn_i[DW-1:IMM_LSB];
  assign imm_ext = {{IMM_LSB{imm_raw[IMM_W-1]}}, imm_raw};
  assign f_src   = insn_i[SRC_LSB +: FW];
  assign f_size  = insn_i[SIZE_LSB +: FW];
  assign f_dst   = insn_i[DST_LSB +: FW];

  // Datapaths
  logic [DW-1:0] alu_res, field_res, addi_res;
  logic          alu_carry, alu_carry_wr, alu_bad;

  macro_alu_arith #(.DW(DW)) u_arith (
    .a_i        (opa_i),
    .b_i        (opb_i),
    .op_i       (alu_op_i),
    .carry_i    (carry_o),
    .res_o      (alu_res),
    .carry_o    (alu_carry),
    .carry_wr_o (alu_carry_wr),
    .bad_o      (alu_bad)
  );

  macro_alu_field #(.DW(DW), .FW(FW)) u_field (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .src_i  (f_src),
    .size_i (f_size),
    .dst_i  (f_dst),
    .res_o  (field_res)
  );

  assign addi_res = opa_i + imm_ext;

  // Next-state selection
  logic [DW-1:0] res_d;
  logic          carry_d, illegal_d;

  always_comb begin
    res_d     = '0;
    carry_d   = carry_o;
    illegal_d = 1'b0;
    unique case (unit_e'(unit_i))
      UNIT_ALU: begin
        res_d     = alu_res;
        illegal_d = alu_bad;
        if (alu_carry_wr) carry_d = alu_carry;
      end
      UNIT_ADDI:  res_d = addi_res;
      UNIT_FIELD: res_d = field_res;
      default:    illegal_d = 1'b1;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      carry_o  <= 1'b0;
    end else if (issue_i) begin
      result_o <= res_d;
      carry_o  <= carry_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_o <= 1'b0;
    else        illegal_o <= issue_i & illegal_d;
  end

  // Assertions
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> ($stable(result_o) && $stable(carry_o) && !illegal_o));

  assert_logic_keeps_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && unit_i == UNIT_ALU && alu_op_i >= 5'd8 && alu_op_i <= 5'd12)
      |=> $stable(carry_o));

  assert_addi_keeps_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && unit_i == UNIT_ADDI) |=> $stable(carry_o));

  assert_size_zero_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && unit_i == UNIT_FIELD && f_size == '0) |=> (result_o == $past(opa_i)));

  assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (result_o == '0 && $past(issue_i)));

  assert_illegal_keeps_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && unit_i == UNIT_RSVD) |=> ($stable(carry_o) && illegal_o));

endmodule

// File: tb/test_macro_alu.sv
`timescale 1ns/1ps
module test_macro_alu;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [1:0]  unit;
  logic [4:0]  op;
  logic [31:0] insn, a, b;
  logic [31:0] result;
  logic        carry, illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Reference model state
  bit [31:0] m_res;
  bit        m_carry;
  bit        m_ill;

  always #4 clk = ~clk;

  macro_alu i_macro_alu (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .unit_i(unit), .alu_op_i(op),
    .insn_i(insn), .opa_i(a), .opb_i(b),
    .result_o(result), .carry_o(carry), .illegal_o(illegal)
  );

  function automatic bit [31:0] w_imm(input bit [17:0] imm);
    return {imm, 14'b0};
  endfunction

  function automatic bit [31:0] w_fld(input int src, input int size, input int dst);
    bit [31:0] w = '0;
    w[21:17] = src[4:0];
    w[26:22] = size[4:0];
    w[31:27] = dst[4:0];
    return w;
  endfunction

  task automatic compare(input string tag);
    n_checks++;
    if (result !== m_res || carry !== m_carry || illegal !== m_ill) begin
      n_fail++;
      $display("FAIL %s: got res=%h c=%b ill=%b, expected res=%h c=%b ill=%b",
               tag, result, carry, illegal, m_res, m_carry, m_ill);
    end
  endtask

  task automatic model(input bit iss, input bit [1:0] u, input bit [4:0] o,
                       input bit [31:0] w, input bit [31:0] x, input bit [31:0] y);
    longint s;
    int     sz, sp, dp;
    bit [31:0] r;
    m_ill = 0;
    if (!iss) return;
    if (u == 2'd0) begin
      case (o)
        5'd0, 5'd1: begin
          s = longint'(x) + longint'(y) + ((o == 5'd1) ? longint'(m_carry) : 0);
          m_res = s[31:0]; m_carry = (s >= 64'sh1_0000_0000);
        end
        5'd2, 5'd3: begin
          s = longint'(x) - longint'(y) - ((o == 5'd3) ? longint'(!m_carry) : 0);
          m_res = s[31:0]; m_carry = (s >= 0);
        end
        5'd8:  m_res = x ^ y;
        5'd9:  m_res = x | y;
        5'd10: m_res = x & y;
        5'd11: m_res = x & ~y;
        5'd12: m_res = ~(x & y);
        default: begin m_res = 0; m_ill = 1; end
      endcase
    end else if (u == 2'd1) begin
      s = longint'(x) + longint'($signed(w[31:14]));
      m_res = s[31:0];
    end else if (u == 2'd2) begin
      sp = int'(w[21:17]); sz = int'(w[26:22]); dp = int'(w[31:27]);
      r = x;
      for (int i = 0; i < sz; i++)
        if (dp + i < 32) r[dp+i] = (sp + i < 32) ? y[sp+i] : 1'b0;
      m_res = r;
    end else begin
      m_res = 0; m_ill = 1;
    end
  endtask

  task automatic step(input bit iss, input bit [1:0] u, input bit [4:0] o,
                      input bit [31:0] w, input bit [31:0] x, input bit [31:0] y,
                      input string tag);
    @(negedge clk);
    issue = iss; unit = u; op = o; insn = w; a = x; b = y;
    model(iss, u, o, w, x, y);
    @(posedge clk);
    #2;
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 2'd0, 5'd0, 32'h0, 32'hDEAD_BEEF, 32'h1234_5678, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; issue = 0; unit = 0; op = 0; insn = 0; a = 0; b = 0;
    m_res = 0; m_carry = 0; m_ill = 0;
    repeat (3) @(posedge clk);
    #2 compare("R1 in reset");
    @(negedge clk) rst_n = 1;
    @(posedge clk); #2 compare("R1 after release");

    // R3 add / add-with-carry
    step(1, 0, 5'd0, 0, 32'd5, 32'd7, "R3 add");
    step(1, 0, 5'd0, 0, 32'hFFFF_FFFF, 32'd1, "R3 add carry out");
    step(1, 0, 5'd1, 0, 32'd10, 32'd20, "R3 adc cin=1");
    step(1, 0, 5'd1, 0, 32'h8000_0000, 32'h8000_0000, "R3 adc carry out");
    step(1, 0, 5'd1, 0, 32'hFFFF_FFFF, 32'd0, "R3 adc cin=1 wrap");
    idle("R2 hold");
    idle("R2 hold again");

    // R4 sub / sub-with-borrow
    step(1, 0, 5'd2, 0, 32'd10, 32'd3, "R4 sub no borrow");
    step(1, 0, 5'd2, 0, 32'd3, 32'd10, "R4 sub borrow");
    step(1, 0, 5'd3, 0, 32'd10, 32'd3, "R4 sbb carry=0");
    step(1, 0, 5'd3, 0, 32'd5, 32'd5, "R4 sbb carry=1");
    step(1, 0, 5'd2, 0, 32'd7, 32'd7, "R4 sub equal");
    step(1, 0, 5'd2, 0, 32'd0, 32'd1, "R4 sub to borrow");
    step(1, 0, 5'd3, 0, 32'd0, 32'd0, "R4 sbb 0-0-1");

    // R5 logic ops, carry preserved (set carry to 1 first)
    step(1, 0, 5'd0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 set carry");
    step(1, 0, 5'd8,  0, 32'hF0F0_1234, 32'h0FF0_4321, "R5 xor");
    step(1, 0, 5'd9,  0, 32'hF0F0_1234, 32'h0FF0_4321, "R5 or");
    step(1, 0, 5'd10, 0, 32'hF0F0_1234, 32'h0FF0_4321, "R5 and");
    step(1, 0, 5'd11, 0, 32'hF0F0_1234, 32'h0FF0_4321, "R5 andnot");
    step(1, 0, 5'd12, 0, 32'hF0F0_1234, 32'h0FF0_4321, "R5 nand");

    // R6 add-immediate
    step(1, 1, 5'd0, w_imm(18'd100), 32'd1000, 32'hFFFF, "R6 addi positive");
    step(1, 1, 5'd0, w_imm(18'h3FFFF), 32'd0, 32'd0, "R6 addi minus one");
    step(1, 1, 5'd0, w_imm(18'h20000), 32'd5, 32'd0, "R6 addi most negative");
    step(1, 1, 5'd0, w_imm(18'h1FFFF), 32'hFFFF_FFFF, 32'd0, "R6 addi wrap");

    // R7 / R8 field merge
    step(1, 2, 5'd0, w_fld(4, 8, 16), 32'h1234_5678, 32'hABCD_EF98, "R7 field mid");
    step(1, 2, 5'd0, w_fld(0, 31, 0), 32'h0, 32'hFFFF_FFFF, "R7 field wide");
    step(1, 2, 5'd0, w_fld(0, 8, 28), 32'h0000_0000, 32'h0000_00AB, "R7 field dst truncate");
    step(1, 2, 5'd0, w_fld(28, 8, 0), 32'hFFFF_FFFF, 32'hC000_0000, "R7 field src truncate");
    step(1, 2, 5'd0, w_fld(3, 0, 9), 32'hCAFE_F00D, 32'hFFFF_FFFF, "R8 size zero");
    step(1, 2, 5'd0, w_fld(31, 0, 31), 32'h0BAD_0001, 32'h0, "R8 size zero edge");

    // R9 illegal codes
    step(1, 0, 5'd2, 0, 32'd1, 32'd0, "R4 set carry");
    step(1, 0, 5'd5, 0, 32'd9, 32'd9, "R9 code 5");
    idle("R9 pulse ends");
    step(1, 0, 5'd13, 0, 32'd9, 32'd9, "R9 code 13");
    step(1, 0, 5'd31, 0, 32'd9, 32'd9, "R9 code 31");
    step(1, 3, 5'd0, 0, 32'd9, 32'd9, "R9 reserved unit");
    step(1, 0, 5'd4, 0, 32'd1, 32'd1, "R9 code 4");
    step(1, 0, 5'd1, 0, 32'd1, 32'd1, "R3 adc after illegal");
    idle("R2 final hold");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule